// File: doc/BRIEF.md
# Dual-Bank Pointer-Addressed Operand Memory

This block keeps two separate banks of 16-bit two's-complement words, 256 words each. No port carries a memory address. Every access names one of four 8-bit pointer registers that belong to its bank. The access can then leave that pointer alone, step it up by one or step it down by one. A loop that walks a coefficient buffer and a sample buffer therefore needs no address arithmetic outside the block.

Each bank has its own read port and its own write port. Both banks are read in the same clock cycle, so one word from each bank arrives together, ready to feed a multiplier. A separate load port sets any pointer of either bank to a given value. Reads are registered and have one cycle of latency. The pointer used for an access is the value it held before that access changed it.

Top module: `dual_ptr_ram`

## Requirements
- R1: A read with the read enable high returns the word at the address held by the selected pointer of that bank (2-bit select, pointers 0 to 3). The word is on the read output one clock edge after the request.
- R2: Bank A and bank B are read in the same cycle, each with its own pointer select and modify code, and both words appear in the same cycle.
- R3: Each access carries a 2-bit modify code: 2'b00 holds the pointer, 2'b01 adds one, 2'b10 subtracts one, and 2'b11 holds. The access uses the old pointer value, and the new value applies from the next cycle.
- R4: Pointers are 8 bits wide and wrap in both directions: 255 plus one gives 0, and 0 minus one gives 255.
- R5: A write with the write enable high stores the write data at the address held by the selected write pointer of that bank. That pointer is then modified by the write's own modify code.
- R6: When a read and a write in one bank use the same address in the same cycle, the read returns the word held before the write.
- R7: A load with the load enable high writes the load value into the pointer chosen by the load bank bit (0 for bank A, 1 for bank B) and the load select. If a modify targets the same pointer in the same cycle, the load wins.
- R8: When the read and the write of one bank select the same pointer in the same cycle, the read's modify code is applied and the write's modify code is ignored.
- R9: A synchronous reset clears all eight pointers to 0 and both read outputs to 0. Memory contents are not cleared.
- R10: While a port's read enable is low, its read output keeps its last value and its modify code has no effect on any pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Pointer load request |
| ld_bank | input | 1 | Bank of the pointer to load (0 = A, 1 = B) |
| ld_sel | input | 2 | Index of the pointer to load |
| ld_val | input | 8 | Value written into the chosen pointer |
| a_rd_en | input | 1 | Bank A read request |
| a_rd_sel | input | 2 | Bank A read pointer index |
| a_rd_mod | input | 2 | Bank A read pointer modify code |
| b_rd_en | input | 1 | Bank B read request |
| b_rd_sel | input | 2 | Bank B read pointer index |
| b_rd_mod | input | 2 | Bank B read pointer modify code |
| a_wr_en | input | 1 | Bank A write request |
| a_wr_sel | input | 2 | Bank A write pointer index |
| a_wr_mod | input | 2 | Bank A write pointer modify code |
| a_wr_data | input | 16 | Bank A write word |
| b_wr_en | input | 1 | Bank B write request |
| b_wr_sel | input | 2 | Bank B write pointer index |
| b_wr_mod | input | 2 | Bank B write pointer modify code |
| b_wr_data | input | 16 | Bank B write word |
| a_rd_data | output | 16 | Registered bank A read word |
| b_rd_data | output | 16 | Registered bank B read word |

## Verification
No port exposes a pointer, so a wrong pointer shows up only as a wrong word the next time that pointer is used for a read. That word appears one edge after the request that used it. The bench therefore fills both banks with address-tagged words, so any returned word names the address it came from. It then follows each modify with a read through the same pointer and checks the address by the tag. Priority mistakes (load against modify, read modify against write modify) and wrap errors turn into a wrong tag within two cycles. A bank mix-up shows as the other bank's tag.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Pointer modify codes carried by every access
  typedef enum logic [1:0] {
    MOD_HOLD = 2'b00,
    MOD_INC  = 2'b01,
    MOD_DEC  = 2'b10,
    MOD_RSVD = 2'b11
  } mod_e;

  localparam int NUM_BANKS = 2;

endpackage

// File: rtl/dpr_ptr_file.sv
module dpr_ptr_file #(
  parameter int ADDR_W  = 8,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int FLAT_W = NUM_PTR * ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [1:0]        rd_mod,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_mod,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [FLAT_W-1:0] ptr_flat
);
  import dpr_pkg::*;

  logic [ADDR_W-1:0] ptr_q [NUM_PTR];

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] v,
                                             input logic [1:0] code);
    case (mod_e'(code))
      MOD_INC: step = v + ADDR_W'(1);
      MOD_DEC: step = v - ADDR_W'(1);
      default: step = v;
    endcase
  endfunction

  // Each pointer: load first, then the read modify, then the write modify
  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    logic hit_ld, hit_rd, hit_wr;
    assign hit_ld = ld_en && (ld_sel == SEL_W'(p));
    assign hit_rd = rd_en && (rd_sel == SEL_W'(p));
    assign hit_wr = wr_en && (wr_sel == SEL_W'(p));

    always_ff @(posedge clk) begin
      if (rst)         ptr_q[p] <= '0;
      else if (hit_ld) ptr_q[p] <= ld_val;
      else if (hit_rd) ptr_q[p] <= step(ptr_q[p], rd_mod);
      else if (hit_wr) ptr_q[p] <= step(ptr_q[p], wr_mod);
    end

    assign ptr_flat[p*ADDR_W +: ADDR_W] = ptr_q[p];
  end

  // Accesses address memory with the pre-modify pointer value
  assign rd_addr = ptr_q[rd_sel];
  assign wr_addr = ptr_q[wr_sel];

endmodule

// File: rtl/dpr_mem_bank.sv
module dpr_mem_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Read-first output register with synchronous reset
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/dual_ptr_ram.sv
module dual_ptr_ram #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int FLAT_W = NUM_PTR * ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_bank,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              a_rd_en,
  input  logic [SEL_W-1:0]  a_rd_sel,
  input  logic [1:0]        a_rd_mod,
  input  logic              b_rd_en,
  input  logic [SEL_W-1:0]  b_rd_sel,
  input  logic [1:0]        b_rd_mod,
  input  logic              a_wr_en,
  input  logic [SEL_W-1:0]  a_wr_sel,
  input  logic [1:0]        a_wr_mod,
  input  logic [DATA_W-1:0] a_wr_data,
  input  logic              b_wr_en,
  input  logic [SEL_W-1:0]  b_wr_sel,
  input  logic [1:0]        b_wr_mod,
  input  logic [DATA_W-1:0] b_wr_data,
  output logic [DATA_W-1:0] a_rd_data,
  output logic [DATA_W-1:0] b_rd_data
);
  import dpr_pkg::*;

  // Per-bank views of the port set
  logic              bk_rd_en   [NUM_BANKS];
  logic [SEL_W-1:0]  bk_rd_sel  [NUM_BANKS];
  logic [1:0]        bk_rd_mod  [NUM_BANKS];
  logic              bk_wr_en   [NUM_BANKS];
  logic [SEL_W-1:0]  bk_wr_sel  [NUM_BANKS];
  logic [1:0]        bk_wr_mod  [NUM_BANKS];
  logic [DATA_W-1:0] bk_wr_data [NUM_BANKS];
  logic [DATA_W-1:0] bk_rd_data [NUM_BANKS];
  logic [FLAT_W-1:0] bk_ptrs    [NUM_BANKS];
  logic [FLAT_W-1:0] a_ptr_flat;
  logic [FLAT_W-1:0] b_ptr_flat;

  assign bk_rd_en[0]   = a_rd_en;    assign bk_rd_en[1]   = b_rd_en;
  assign bk_rd_sel[0]  = a_rd_sel;   assign bk_rd_sel[1]  = b_rd_sel;
  assign bk_rd_mod[0]  = a_rd_mod;   assign bk_rd_mod[1]  = b_rd_mod;
  assign bk_wr_en[0]   = a_wr_en;    assign bk_wr_en[1]   = b_wr_en;
  assign bk_wr_sel[0]  = a_wr_sel;   assign bk_wr_sel[1]  = b_wr_sel;
  assign bk_wr_mod[0]  = a_wr_mod;   assign bk_wr_mod[1]  = b_wr_mod;
  assign bk_wr_data[0] = a_wr_data;  assign bk_wr_data[1] = b_wr_data;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              ld_here;

    assign ld_here = ld_en && (ld_bank == 1'(b));

    dpr_ptr_file #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_ptrs (
      .clk     (clk),
      .rst     (rst),
      .ld_en   (ld_here),
      .ld_sel  (ld_sel),
      .ld_val  (ld_val),
      .rd_en   (bk_rd_en[b]),
      .rd_sel  (bk_rd_sel[b]),
      .rd_mod  (bk_rd_mod[b]),
      .wr_en   (bk_wr_en[b]),
      .wr_sel  (bk_wr_sel[b]),
      .wr_mod  (bk_wr_mod[b]),
      .rd_addr (rd_addr),
      .wr_addr (wr_addr),
      .ptr_flat(bk_ptrs[b])
    );

    dpr_mem_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk    (clk),
      .rst    (rst),
      .rd_en  (bk_rd_en[b]),
      .rd_addr(rd_addr),
      .wr_en  (bk_wr_en[b]),
      .wr_addr(wr_addr),
      .wr_data(bk_wr_data[b]),
      .rd_data(bk_rd_data[b])
    );
  end

  assign a_rd_data  = bk_rd_data[0];
  assign b_rd_data  = bk_rd_data[1];
  assign a_ptr_flat = bk_ptrs[0];
  assign b_ptr_flat = bk_ptrs[1];

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int FLAT_W = NUM_PTR * ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_en,
  input logic              ld_bank,
  input logic [SEL_W-1:0]  ld_sel,
  input logic [ADDR_W-1:0] ld_val,
  input logic              a_rd_en,
  input logic [SEL_W-1:0]  a_rd_sel,
  input logic [1:0]        a_rd_mod,
  input logic              b_rd_en,
  input logic [DATA_W-1:0] a_rd_data,
  input logic [DATA_W-1:0] b_rd_data,
  input logic [FLAT_W-1:0] a_ptr_flat,
  input logic [FLAT_W-1:0] b_ptr_flat
);

  function automatic logic [ADDR_W-1:0] pick(input logic [FLAT_W-1:0] v,
                                             input logic [SEL_W-1:0] s);
    pick = v[s*ADDR_W +: ADDR_W];
  endfunction

  logic a_ld_clash;
  assign a_ld_clash = ld_en && !ld_bank && (ld_sel == a_rd_sel);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (a_rd_data == '0 && b_rd_data == '0 && a_ptr_flat == '0 && b_ptr_flat == '0)); // R9

  AST_A_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !a_rd_en |=> $stable(a_rd_data)); // R10

  AST_B_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !b_rd_en |=> $stable(b_rd_data)); // R10

  AST_A_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !ld_bank) |=> pick(a_ptr_flat, $past(ld_sel)) == $past(ld_val)); // R7

  AST_B_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_bank) |=> pick(b_ptr_flat, $past(ld_sel)) == $past(ld_val)); // R7

  AST_A_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_rd_mod == 2'b01 && !a_ld_clash) |=>
      pick(a_ptr_flat, $past(a_rd_sel)) ==
      ADDR_W'(pick($past(a_ptr_flat), $past(a_rd_sel)) + ADDR_W'(1))); // R4

  AST_A_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_rd_mod == 2'b10 && !a_ld_clash) |=>
      pick(a_ptr_flat, $past(a_rd_sel)) ==
      ADDR_W'(pick($past(a_ptr_flat), $past(a_rd_sel)) - ADDR_W'(1))); // R3

  AST_A_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_rd_mod == 2'b11 && !a_ld_clash) |=>
      pick(a_ptr_flat, $past(a_rd_sel)) == pick($past(a_ptr_flat), $past(a_rd_sel))); // R3

endmodule

bind dual_ptr_ram dpr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_dpr_checker (
  .clk       (clk),
  .rst       (rst),
  .ld_en     (ld_en),
  .ld_bank   (ld_bank),
  .ld_sel    (ld_sel),
  .ld_val    (ld_val),
  .a_rd_en   (a_rd_en),
  .a_rd_sel  (a_rd_sel),
  .a_rd_mod  (a_rd_mod),
  .b_rd_en   (b_rd_en),
  .a_rd_data (a_rd_data),
  .b_rd_data (b_rd_data),
  .a_ptr_flat(a_ptr_flat),
  .b_ptr_flat(b_ptr_flat)
);

// File: tb/test_dual_ptr_ram.sv
module test_dual_ptr_ram;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en, ld_bank;
  logic [1:0]  ld_sel;
  logic [7:0]  ld_val;
  logic        a_rd_en, b_rd_en, a_wr_en, b_wr_en;
  logic [1:0]  a_rd_sel, a_rd_mod, b_rd_sel, b_rd_mod;
  logic [1:0]  a_wr_sel, a_wr_mod, b_wr_sel, b_wr_mod;
  logic [15:0] a_wr_data, b_wr_data, a_rd_data, b_rd_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_ptr_ram i_dual_ptr_ram (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_bank(ld_bank), .ld_sel(ld_sel), .ld_val(ld_val),
    .a_rd_en(a_rd_en), .a_rd_sel(a_rd_sel), .a_rd_mod(a_rd_mod),
    .b_rd_en(b_rd_en), .b_rd_sel(b_rd_sel), .b_rd_mod(b_rd_mod),
    .a_wr_en(a_wr_en), .a_wr_sel(a_wr_sel), .a_wr_mod(a_wr_mod), .a_wr_data(a_wr_data),
    .b_wr_en(b_wr_en), .b_wr_sel(b_wr_sel), .b_wr_mod(b_wr_mod), .b_wr_data(b_wr_data),
    .a_rd_data(a_rd_data), .b_rd_data(b_rd_data)
  );

  // Dual-read vectors: {a_sel, a_mod, b_sel, b_mod, expected A word, expected B word}
  localparam int NVEC = 7;
  localparam logic [39:0] VEC [NVEC] = '{
    {2'd1, 2'b01, 2'd3, 2'b10, 16'hA000, 16'hB007},
    {2'd1, 2'b01, 2'd3, 2'b10, 16'hA001, 16'hB006},
    {2'd2, 2'b00, 2'd1, 2'b00, 16'hA005, 16'hB000},
    {2'd2, 2'b10, 2'd3, 2'b11, 16'hA005, 16'hB005},
    {2'd2, 2'b00, 2'd3, 2'b01, 16'hA004, 16'hB005},
    {2'd1, 2'b10, 2'd3, 2'b00, 16'hA002, 16'hB006},
    {2'd1, 2'b00, 2'd2, 2'b00, 16'hA001, 16'hB000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_en = 0; ld_bank = 0; ld_sel = 0; ld_val = 0;
    a_rd_en = 0; a_rd_sel = 0; a_rd_mod = 0;
    b_rd_en = 0; b_rd_sel = 0; b_rd_mod = 0;
    a_wr_en = 0; a_wr_sel = 0; a_wr_mod = 0; a_wr_data = 0;
    b_wr_en = 0; b_wr_sel = 0; b_wr_mod = 0; b_wr_data = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) step();
    chk("R9 reset A out", a_rd_data, 16'h0000);
    chk("R9 reset B out", b_rd_data, 16'h0000);
    rst = 0;

    // Fill both banks through write pointer 0 with post-increment (R5)
    for (int i = 0; i < 8; i++) begin
      a_wr_en = 1; a_wr_sel = 0; a_wr_mod = 2'b01; a_wr_data = 16'hA000 + 16'(i);
      b_wr_en = 1; b_wr_sel = 0; b_wr_mod = 2'b01; b_wr_data = 16'hB000 + 16'(i);
      step();
    end
    idle();
    ld_en = 1; ld_bank = 0; ld_sel = 2; ld_val = 8'd5; step();
    ld_bank = 1; ld_sel = 3; ld_val = 8'd7; step();
    idle();

    // R1 R2 R3: dual fetch walk
    for (int v = 0; v < NVEC; v++) begin
      a_rd_en = 1; b_rd_en = 1;
      {a_rd_sel, a_rd_mod, b_rd_sel, b_rd_mod} = VEC[v][39:32];
      step();
      chk("R1 R3 vector A", a_rd_data, VEC[v][31:16]);
      chk("R2 R3 vector B", b_rd_data, VEC[v][15:0]);
    end

    // R10: disabled read with increment code changes nothing
    idle(); a_rd_sel = 1; a_rd_mod = 2'b01; step();
    chk("R10 hold A out", a_rd_data, 16'hA001);
    chk("R10 hold B out", b_rd_data, 16'hB000);
    idle(); a_rd_en = 1; a_rd_sel = 1; step();
    chk("R10 pointer untouched", a_rd_data, 16'hA001);

    // R4 R5: wrap at top and bottom
    idle(); ld_en = 1; ld_sel = 3; ld_val = 8'hFF; step();
    idle(); a_wr_en = 1; a_wr_sel = 3; a_wr_mod = 2'b01; a_wr_data = 16'h5A5A; step();
    idle(); a_rd_en = 1; a_rd_sel = 3; a_rd_mod = 2'b10; step();
    chk("R4 wrap 255+1", a_rd_data, 16'hA000);
    a_rd_mod = 2'b00; step();
    chk("R4 R5 wrap 0-1 write", a_rd_data, 16'h5A5A);

    // R6: read-first on same address
    idle(); a_wr_en = 1; a_wr_sel = 2; a_wr_data = 16'h1234; a_rd_en = 1; a_rd_sel = 2; step();
    chk("R6 old data", a_rd_data, 16'hA004);
    idle(); a_rd_en = 1; a_rd_sel = 2; step();
    chk("R6 new data", a_rd_data, 16'h1234);

    // R8: read modify wins over write modify on one pointer
    idle(); a_rd_en = 1; a_rd_sel = 1; a_rd_mod = 2'b01;
    a_wr_en = 1; a_wr_sel = 1; a_wr_mod = 2'b10; a_wr_data = 16'hCAFE; step();
    chk("R8 read-first", a_rd_data, 16'hA001);
    idle(); a_rd_en = 1; a_rd_sel = 1; step();
    chk("R8 read modify wins", a_rd_data, 16'hA002);

    // R7: load beats modify on the same pointer
    idle(); ld_en = 1; ld_sel = 0; ld_val = 8'd3; a_rd_en = 1; a_rd_sel = 0; a_rd_mod = 2'b01; step();
    idle(); a_rd_en = 1; a_rd_sel = 0; step();
    chk("R7 load wins", a_rd_data, 16'hA003);

    // R7: load steered to bank B only
    idle(); ld_en = 1; ld_bank = 1; ld_sel = 0; ld_val = 8'd2; step();
    idle(); a_rd_en = 1; b_rd_en = 1; step();
    chk("R7 bank A untouched", a_rd_data, 16'hA003);
    chk("R7 bank B loaded", b_rd_data, 16'hB002);

    // R9: reset mid-run clears pointers and outputs
    idle(); rst = 1; step();
    chk("R9 mid reset A", a_rd_data, 16'h0000);
    chk("R9 mid reset B", b_rd_data, 16'h0000);
    rst = 0; a_rd_en = 1; a_rd_sel = 1; b_rd_en = 1; b_rd_sel = 3; step();
    chk("R9 A pointer zero", a_rd_data, 16'hA000);
    chk("R9 B pointer zero", b_rd_data, 16'hB000);

    idle();
    step();
    finish_run();
  end

endmodule